// File: doc/BRIEF.md
# Protection Region Bound Decoder

This block turns the address-match settings of a bank of memory protection entries into explicit inclusive byte ranges. For each entry it takes a 2-bit match mode and a word-granular address register. It returns a registered lowest byte address, a registered highest byte address and a valid flag. An access checker elsewhere compares a request address against these pairs and never has to decode the modes itself.

An address register holds a byte address with its two low bits dropped. A range can be set four ways. In top-of-range form, the entry below supplies the base. A single four-byte word can be named directly. A naturally aligned power-of-two region takes its size from the run of trailing ones in the register. All entries are decoded in parallel. The results are captured on every rising clock edge, so a change to one register reaches every range that depends on it, including the next entry's top-of-range base, with the same one-cycle delay.

Top module: `pbd_region_bounds`

## Requirements
- R1: While reset is asserted, and on the first edge after it, every lo_o and hi_o field reads 0 and every valid_o bit reads 0.
- R2: The outputs show the decode of mode_i and addr_i as sampled at the previous rising clock edge. Between edges they hold steady, even when the inputs change.
- R3: An entry in off mode (code 0) gives valid 0, a lowest address of 0 and a highest address of all ones, whatever its address register holds.
- R4: In top-of-range mode (code 1), the lowest address is the previous entry's register shifted left by 2 and the highest is this entry's register shifted left by 2, minus 1, taken modulo 2^(ADDR_W+2). Entry 0 uses 0 as its previous register.
- R5: In top-of-range mode, when the computed lowest address is above the computed highest, both are 0 and valid stays 1.
- R6: In four-byte mode (code 2), the lowest address is the register shifted left by 2 and the highest is that value plus 3.
- R7: In power-of-two mode (code 3), with y = (register << 2) | 3, the lowest address is y AND (y+1) and the highest is y OR (y+1). No trailing ones in the register gives 8 bytes, and each further trailing one doubles the size. An all-ones register covers the whole space.
- R8: A change to register k alone updates a top-of-range entry k+1 on the same edge that updates entry k.
- R9: Entry k's mode is mode_i[2k+1:2k], its register is addr_i[k*ADDR_W +: ADDR_W], and its bounds are lo_o/hi_o[k*(ADDR_W+2) +: ADDR_W+2]. valid_o[k] is 1 exactly when the mode code is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2*NUM_ENTRIES | Match mode per entry |
| addr_i | input | NUM_ENTRIES*ADDR_W | Word-granular address register per entry |
| lo_o | output | NUM_ENTRIES*(ADDR_W+2) | Inclusive lowest byte address per entry |
| hi_o | output | NUM_ENTRIES*(ADDR_W+2) | Inclusive highest byte address per entry |
| valid_o | output | NUM_ENTRIES | Entry active flag |

## Verification
Every bound and valid bit has one register between the inputs and the ports. A new setting is therefore due one rising edge after it is applied. The bench drives the inputs on the falling edge and reads the outputs on the next falling edge, half a period after the capturing edge. One directed case reads the outputs after new inputs are driven but before the next rising edge, to confirm that the old values are still held. The neighbour-refresh case changes only one register between two table rows and expects the following top-of-range entry to have moved by the next read.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
   typedef enum logic [1:0] {
      PBD_OFF   = 2'd0,
      PBD_TOR   = 2'd1,
      PBD_NA4   = 2'd2,
      PBD_NAPOT = 2'd3
   } pbd_mode_e;
endpackage

// File: rtl/pbd_napot.sv
module pbd_napot #(
   parameter int unsigned ADDR_W = 30
) (
   input  logic [ADDR_W-1:0]   addr_i,
   output logic [ADDR_W+1:0]   lo_o,
   output logic [ADDR_W+1:0]   hi_o
);
   localparam int unsigned BW = ADDR_W + 2;
   localparam logic [BW-1:0] ONE = {{(BW-1){1'b0}}, 1'b1};

   logic [BW-1:0] y;
   logic [BW-1:0] y_inc;
   logic [BW-1:0] span;

   always_comb begin
      y     = {addr_i, 2'b11};
      y_inc = y + ONE;
      lo_o  = y & y_inc;
      hi_o  = y | y_inc;
      span  = hi_o - lo_o;
      // R7: the region is a power of two in size and aligned to that size
      a_r7_napot_aligned: assert (((span + ONE) & span) == '0 && (lo_o & span) == '0);
   end
endmodule

// File: rtl/pbd_entry_decode.sv
module pbd_entry_decode
   import pbd_pkg::*;
#(
   parameter int unsigned ADDR_W = 30
) (
   input  logic [1:0]          mode_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [ADDR_W-1:0]   prev_i,
   output logic [ADDR_W+1:0]   lo_o,
   output logic [ADDR_W+1:0]   hi_o,
   output logic                valid_o
);
   localparam int unsigned BW = ADDR_W + 2;
   localparam logic [BW-1:0] ONE = {{(BW-1){1'b0}}, 1'b1};

   logic [BW-1:0] np_lo;
   logic [BW-1:0] np_hi;
   logic [BW-1:0] tor_lo;
   logic [BW-1:0] tor_hi;
   logic [BW-1:0] word_base;

   pbd_napot #(.ADDR_W(ADDR_W)) u_napot (
      .addr_i (addr_i),
      .lo_o   (np_lo),
      .hi_o   (np_hi)
   );

   always_comb begin
      word_base = {addr_i, 2'b00};
      tor_lo    = {prev_i, 2'b00};
      tor_hi    = word_base - ONE;
      lo_o      = '0;
      hi_o      = '1;
      valid_o   = 1'b0;
      unique case (pbd_mode_e'(mode_i))
         PBD_OFF: begin
            lo_o = '0;
            hi_o = '1;
         end
         PBD_TOR: begin
            valid_o = 1'b1;
            if (tor_lo > tor_hi) begin
               lo_o = '0;
               hi_o = '0;
            end else begin
               lo_o = tor_lo;
               hi_o = tor_hi;
            end
         end
         PBD_NA4: begin
            valid_o = 1'b1;
            lo_o    = word_base;
            hi_o    = word_base + BW'(3);
         end
         PBD_NAPOT: begin
            valid_o = 1'b1;
            lo_o    = np_lo;
            hi_o    = np_hi;
         end
         default: begin
            lo_o = '0;
            hi_o = '1;
         end
      endcase
   end
endmodule

// File: rtl/pbd_region_bounds.sv
module pbd_region_bounds #(
   parameter int unsigned NUM_ENTRIES = 4,
   parameter int unsigned ADDR_W      = 30
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [2*NUM_ENTRIES-1:0]           mode_i,
   input  logic [NUM_ENTRIES*ADDR_W-1:0]      addr_i,
   output logic [NUM_ENTRIES*(ADDR_W+2)-1:0]  lo_o,
   output logic [NUM_ENTRIES*(ADDR_W+2)-1:0]  hi_o,
   output logic [NUM_ENTRIES-1:0]             valid_o
);
   localparam int unsigned BW = ADDR_W + 2;

   if (NUM_ENTRIES < 1) begin : g_bad_entries
      $error("pbd_region_bounds: NUM_ENTRIES must be at least 1");
   end
   if (ADDR_W < 2 || ADDR_W > 62) begin : g_bad_width
      $error("pbd_region_bounds: ADDR_W must lie in 2..62");
   end

   logic chk_armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chk_armed_q <= 1'b0;
      else        chk_armed_q <= 1'b1;
   end

   for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_entry
      logic [ADDR_W-1:0] prev_addr;
      logic [BW-1:0]     lo_d;
      logic [BW-1:0]     hi_d;
      logic              valid_d;
      logic [BW-1:0]     lo_q;
      logic [BW-1:0]     hi_q;
      logic              valid_q;

      if (k == 0) begin : g_base
         assign prev_addr = '0;
      end else begin : g_link
         assign prev_addr = addr_i[(k-1)*ADDR_W +: ADDR_W];
      end

      pbd_entry_decode #(.ADDR_W(ADDR_W)) u_dec (
         .mode_i  (mode_i[2*k +: 2]),
         .addr_i  (addr_i[k*ADDR_W +: ADDR_W]),
         .prev_i  (prev_addr),
         .lo_o    (lo_d),
         .hi_o    (hi_d),
         .valid_o (valid_d)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q    <= '0;
            hi_q    <= '0;
            valid_q <= 1'b0;
         end else begin
            lo_q    <= lo_d;
            hi_q    <= hi_d;
            valid_q <= valid_d;
         end
      end

      assign lo_o[k*BW +: BW] = lo_q;
      assign hi_o[k*BW +: BW] = hi_q;
      assign valid_o[k]       = valid_q;

      // R9: valid follows the mode sampled one edge earlier
      a_r9_valid_tracks_mode: assert property (@(posedge clk) disable iff (!rst_n)
         chk_armed_q |-> (valid_q == ($past(mode_i[2*k +: 2]) != 2'd0)));

      // R4 (and R5..R7): an active entry never has its lowest above its highest
      a_r4_bounds_ordered: assert property (@(posedge clk) disable iff (!rst_n)
         valid_q |-> (lo_q <= hi_q));

      // R6: a four-byte entry spans exactly four bytes
      a_r6_na4_span: assert property (@(posedge clk) disable iff (!rst_n)
         (chk_armed_q && $past(mode_i[2*k +: 2]) == 2'd2) |-> ((hi_q - lo_q) == BW'(3)));
   end
endmodule

// File: tb/tb_pbd_region_bounds.sv
module tb_pbd_region_bounds;
   localparam int N  = 4;
   localparam int AW = 30;
   localparam int BW = AW + 2;
   localparam int ROWS = 6;

   typedef struct packed {
      logic [2*N-1:0]  mode;
      logic [N*AW-1:0] addr;
      logic [N*BW-1:0] lo;
      logic [N*BW-1:0] hi;
      logic [N-1:0]    valid;
   } vec_t;

   // Fields are listed entry 3 first, entry 0 last.
   localparam vec_t TBL [ROWS] = '{
      // row 0, R3: all off
      '{mode: {2'd0, 2'd0, 2'd0, 2'd0},
        addr: {30'h400, 30'h300, 30'h200, 30'h100},
        lo:   {32'h0, 32'h0, 32'h0, 32'h0},
        hi:   {32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF},
        valid: 4'b0000},
      // row 1, R4 R6 R7: mixed modes
      '{mode: {2'd1, 2'd3, 2'd2, 2'd1},
        addr: {30'h2000, 30'h1000, 30'h800, 30'h400},
        lo:   {32'h4000, 32'h4000, 32'h2000, 32'h0},
        hi:   {32'h7FFF, 32'h4007, 32'h2003, 32'h0FFF},
        valid: 4'b1111},
      // row 2, R8: only entry 2's register moves, entry 3 (TOR) follows
      '{mode: {2'd1, 2'd3, 2'd2, 2'd1},
        addr: {30'h2000, 30'h1800, 30'h800, 30'h400},
        lo:   {32'h6000, 32'h6000, 32'h2000, 32'h0},
        hi:   {32'h7FFF, 32'h6007, 32'h2003, 32'h0FFF},
        valid: 4'b1111},
      // row 3, R7: power-of-two sizes 16 B, 32 B, whole space, 2 KiB
      '{mode: {2'd3, 2'd3, 2'd3, 2'd3},
        addr: {30'h200000FF, 30'h3FFFFFFF, 30'h103, 30'h1},
        lo:   {32'h80000000, 32'h0, 32'h400, 32'h0},
        hi:   {32'h800007FF, 32'hFFFFFFFF, 32'h41F, 32'hF},
        valid: 4'b1111},
      // row 4, R5 R3: inverted and equal TOR collapse, off entry
      '{mode: {2'd0, 2'd1, 2'd1, 2'd2},
        addr: {30'h600, 30'h400, 30'h400, 30'h500},
        lo:   {32'h0, 32'h0, 32'h0, 32'h1400},
        hi:   {32'hFFFFFFFF, 32'h0, 32'h0, 32'h1403},
        valid: 4'b0111},
      // row 5, R4 R5 R6: TOR at zero wraps, top word, collapse below top
      '{mode: {2'd1, 2'd2, 2'd1, 2'd1},
        addr: {30'h402, 30'h3FFFFFFF, 30'h401, 30'h0},
        lo:   {32'h0, 32'hFFFFFFFC, 32'h0, 32'h0},
        hi:   {32'h0, 32'hFFFFFFFF, 32'h1003, 32'hFFFFFFFF},
        valid: 4'b1111}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [2*N-1:0]   mode_i = '0;
   logic [N*AW-1:0]  addr_i = '0;
   logic [N*BW-1:0]  lo_o;
   logic [N*BW-1:0]  hi_o;
   logic [N-1:0]     valid_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pbd_region_bounds #(.NUM_ENTRIES(N), .ADDR_W(AW)) dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_i  (mode_i),
      .addr_i  (addr_i),
      .lo_o    (lo_o),
      .hi_o    (hi_o),
      .valid_o (valid_o)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic string row_tag(input int r);
      case (r)
         0: return "R3";
         1: return "R4/R6/R7";
         2: return "R8";
         3: return "R7";
         4: return "R5";
         default: return "R4";
      endcase
   endfunction

   task automatic check_all(input string tag, input logic [N*BW-1:0] elo,
                            input logic [N*BW-1:0] ehi, input logic [N-1:0] ev);
      for (int k = 0; k < N; k++) begin
         chk(tag, $sformatf("lo[%0d]", k), lo_o[k*BW +: BW], elo[k*BW +: BW]);
         chk(tag, $sformatf("hi[%0d]", k), hi_o[k*BW +: BW], ehi[k*BW +: BW]);
         chk(tag, $sformatf("valid[%0d]", k), 32'(valid_o[k]), 32'(ev[k]));
      end
   endtask

   initial begin
      #40000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state, while held and after several edges
      repeat (3) @(posedge clk);
      @(negedge clk);
      mode_i = TBL[1].mode;
      addr_i = TBL[1].addr;
      #1;
      check_all("R1", '0, '0, '0);

      rst_n = 1'b1;
      // table walk: drive on falling edge, read one period later
      for (int r = 0; r < ROWS; r++) begin
         @(negedge clk);
         mode_i = TBL[r].mode;
         addr_i = TBL[r].addr;
         @(negedge clk);
         check_all(row_tag(r), TBL[r].lo, TBL[r].hi, TBL[r].valid);
      end

      // R2: new inputs do not show before the next rising edge
      @(negedge clk);
      mode_i = TBL[0].mode;
      addr_i = TBL[0].addr;
      #1;
      chk("R2", "hold hi[1]", hi_o[1*BW +: BW], 32'h1003);
      chk("R2", "hold valid", 32'(valid_o), 32'hF);
      @(negedge clk);
      chk("R2", "update hi[1]", hi_o[1*BW +: BW], 32'hFFFFFFFF);
      chk("R2", "update valid", 32'(valid_o), 32'h0);

      // R1: reset in mid-run clears everything
      mode_i = TBL[1].mode;
      addr_i = TBL[1].addr;
      @(negedge clk);
      chk("R1", "pre-reset hi[0]", hi_o[0 +: BW], 32'h0FFF);
      rst_n = 1'b0;
      @(negedge clk);
      check_all("R1", '0, '0, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R4", TBL[1].lo, TBL[1].hi, TBL[1].valid);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule